// File: doc/BRIEF.md
# Steering target resolver

The resolver picks a group/instance pair for a read of a replicated register, so that the read lands on a replica that is neither fused off nor powered down. The request address is compared against a fixed table of inclusive address ranges. Each range carries one of four steering classes. The classes are tried in a fixed priority, and the first class that is enabled and has a hit decides how the target is formed. For most classes the target comes from the lowest present unit, and presence is worked out from fuse and enable inputs. When no class matches, the configured default pair is returned.

A second request mode turns a linear subslice index into a group/instance pair. Requests enter on a valid/ready port and leave on a valid/ready port, through a single output register, so each result appears one cycle after it is accepted. The rules for back-pressure are these. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is presented while `rsp_ready` is low stays unchanged until it is taken. The fuse inputs, class enables and default IDs are plain static inputs, and they are sampled at the moment a request is accepted.

Top module: `steer_resolver`

## Requirements
- R1: Range limits are inclusive. An address equal to a range's low or high bound matches that range, and the address one below the low bound or one above the high bound does not. Ranges: class L3 0xB100–0xB3FF; class MS 0x4000–0x4AFF, 0xC800–0xCFFF, 0xDD00–0xDDFF, 0xE900–0xFFFF; class LN 0xB000–0xB0FF, 0xD800–0xD8FF; class I0 0x8800–0x887F, 0xB000–0xB3FF.
- R2: Priority is L3, then MS, then LN, then I0. The first enabled class with a matching range wins.
- R3: Class L3 returns group 0 and, as instance, the index of the lowest set bit of the L3 bank present mask. `rsp_class` is 1.
- R4: Class MS returns, as group, the index of the lowest present memory slice, and instance 0. `rsp_class` is 2.
- R5: Class LN returns, as group, twice the index of the lowest present memory slice, and instance 0. `rsp_class` is 3.
- R6: Class I0 returns group 0 and instance 0. `rsp_class` is 4.
- R7: An address request that matches no enabled class returns `dflt_group` and `dflt_inst`, with `rsp_class` 0 and `rsp_err` 0.
- R8: Memory slice m is present when `meml3_en[m]` is set or any of `ss_present[m*SS_PER_MS +: SS_PER_MS]` is set. It is absent only when all of these bits are clear.
- R9: The L3 bank present mask is the bitwise inverse of `l3_fuse`. A set fuse bit marks that bank as absent.
- R10: `cls_en` gates the classes: bit 0 is L3, bit 1 is MS, bit 2 is LN and bit 3 is I0. A class whose bit is clear never matches, and the lookup falls through to the next class or to the default.
- R11: If the winning class is L3, MS or LN and its presence mask is all zero, the response has `rsp_err` set and group and instance both 0. The class code is still reported. Otherwise `rsp_err` is 0.
- R12: When `req_ss_mode` is 1, the index `req_addr[SSI_W-1:0]` is mapped to group = index / SS_PER_SLICE and instance = index % SS_PER_SLICE, with `rsp_class` 5.
- R13: After reset `rsp_valid` is 0 and `req_ready` is 1. A request accepted in one cycle is presented in the next. While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_en | input | 4 | Per-class enables: bit 0 L3, bit 1 MS, bit 2 LN, bit 3 I0 |
| l3_fuse | input | NBANK | L3 bank fuse-off bits (1 = bank absent) |
| meml3_en | input | NMSLICE | Memory L3 enable per memory slice |
| ss_present | input | NMSLICE*SS_PER_MS | Subslice present bits |
| dflt_group | input | GRP_W | Default group ID |
| dflt_inst | input | INST_W | Default instance ID |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_ss_mode | input | 1 | 0 = address lookup, 1 = subslice index mapping |
| req_addr | input | ADDR_W | Register address, or subslice index in the low bits |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_group | output | GRP_W | Steering group |
| rsp_inst | output | INST_W | Steering instance |
| rsp_class | output | 3 | 0 default, 1 L3, 2 MS, 3 LN, 4 I0, 5 subslice map |
| rsp_err | output | 1 | Winning class has no present unit |

## Verification
The bench probes every range bound and the address just past it. A design with an exclusive or off-by-one comparison would then return the default pair at a bound, or steer an outside address. It sends addresses where classes overlap, with enables switched off one at a time. A wrong priority or a class that ignores its enable would report the wrong class code. Presence is driven from each side alone (only the memory enable, only a high subslice, and neither), so a slice-presence term that uses AND, or a presence mask that is not inverted, would yield a wrong group or a missing error. A randomly stalled `rsp_ready` checks that a held response neither changes nor gets dropped or duplicated.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [2:0] {
    CLS_DEFAULT = 3'd0,
    CLS_L3BANK  = 3'd1,
    CLS_MSLICE  = 3'd2,
    CLS_LNCF    = 3'd3,
    CLS_INST0   = 3'd4,
    CLS_SSMAP   = 3'd5
  } steer_cls_e;

  // class slots in priority order (bit index of cls_en / hit vector)
  localparam int SLOT_L3   = 0;
  localparam int SLOT_MS   = 1;
  localparam int SLOT_LN   = 2;
  localparam int SLOT_I0   = 3;
  localparam int NUM_SLOTS = 4;

  localparam int NUM_RANGES = 9;
  localparam int TBL_W      = 16;

  function automatic logic [TBL_W-1:0] range_lo(input int r);
    case (r)
      0: range_lo = 16'hB100;
      1: range_lo = 16'h4000;
      2: range_lo = 16'hC800;
      3: range_lo = 16'hDD00;
      4: range_lo = 16'hE900;
      5: range_lo = 16'hB000;
      6: range_lo = 16'hD800;
      7: range_lo = 16'h8800;
      default: range_lo = 16'hB000;
    endcase
  endfunction

  function automatic logic [TBL_W-1:0] range_hi(input int r);
    case (r)
      0: range_hi = 16'hB3FF;
      1: range_hi = 16'h4AFF;
      2: range_hi = 16'hCFFF;
      3: range_hi = 16'hDDFF;
      4: range_hi = 16'hFFFF;
      5: range_hi = 16'hB0FF;
      6: range_hi = 16'hD8FF;
      7: range_hi = 16'h887F;
      default: range_hi = 16'hB3FF;
    endcase
  endfunction

  function automatic logic [1:0] range_slot(input int r);
    case (r)
      0:             range_slot = 2'(SLOT_L3);
      1, 2, 3, 4:    range_slot = 2'(SLOT_MS);
      5, 6:          range_slot = 2'(SLOT_LN);
      default:       range_slot = 2'(SLOT_I0);
    endcase
  endfunction

endpackage

// File: rtl/steer_range_match.sv
module steer_range_match
  import steer_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_SLOTS-1:0] slot_en,
  output logic [NUM_SLOTS-1:0] slot_hit
);
  logic [NUM_RANGES-1:0] rhit;
  logic [NUM_SLOTS-1:0]  slot_raw;

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    localparam logic [TBL_W-1:0] LO = range_lo(r);
    localparam logic [TBL_W-1:0] HI = range_hi(r);
    assign rhit[r] = (addr >= ADDR_W'(LO)) && (addr <= ADDR_W'(HI));
  end

  always_comb begin
    slot_raw = '0;
    for (int r = 0; r < NUM_RANGES; r++)
      if (rhit[r]) slot_raw[range_slot(r)] = 1'b1;
  end

  assign slot_hit = slot_raw & slot_en;
endmodule

// File: rtl/steer_presence.sv
module steer_presence #(
  parameter int NBANK     = 8,
  parameter int NMSLICE   = 4,
  parameter int SS_PER_MS = 4,
  localparam int NSS      = NMSLICE * SS_PER_MS
) (
  input  logic [NBANK-1:0]   l3_fuse,
  input  logic [NMSLICE-1:0] meml3_en,
  input  logic [NSS-1:0]     ss_present,
  output logic [NBANK-1:0]   l3_mask,
  output logic [NMSLICE-1:0] ms_mask
);
  assign l3_mask = ~l3_fuse;

  for (genvar m = 0; m < NMSLICE; m++) begin : g_ms
    assign ms_mask[m] = meml3_en[m] | (|ss_present[m*SS_PER_MS +: SS_PER_MS]);
  end
endmodule

// File: rtl/steer_pick.sv
module steer_pick #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  mask,
  output logic [IW-1:0] idx,
  output logic          none
);
  always_comb begin
    idx = '0;
    for (int b = W - 1; b >= 0; b--)
      if (mask[b]) idx = IW'(b);
  end

  assign none = ~|mask;
endmodule

// File: rtl/steer_ss_map.sv
module steer_ss_map #(
  parameter int SSI_W        = 4,
  parameter int SS_PER_SLICE = 4,
  parameter int GRP_W        = 4,
  parameter int INST_W       = 4
) (
  input  logic [SSI_W-1:0]  ss_idx,
  output logic [GRP_W-1:0]  grp,
  output logic [INST_W-1:0] inst
);
  assign grp  = GRP_W'(32'(ss_idx) / SS_PER_SLICE);
  assign inst = INST_W'(32'(ss_idx) % SS_PER_SLICE);
endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
  import steer_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int NBANK        = 8,
  parameter int NMSLICE      = 4,
  parameter int SS_PER_MS    = 4,
  parameter int SS_PER_SLICE = 4,
  parameter int GRP_W        = 4,
  parameter int INST_W       = 4,
  localparam int NSS         = NMSLICE * SS_PER_MS,
  localparam int SSI_W       = (NSS > 1) ? $clog2(NSS) : 1,
  localparam int BANK_IW     = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int MS_IW       = (NMSLICE > 1) ? $clog2(NMSLICE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cls_en,
  input  logic [NBANK-1:0]  l3_fuse,
  input  logic [NMSLICE-1:0] meml3_en,
  input  logic [NSS-1:0]    ss_present,
  input  logic [GRP_W-1:0]  dflt_group,
  input  logic [INST_W-1:0] dflt_inst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ss_mode,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [GRP_W-1:0]  rsp_group,
  output logic [INST_W-1:0] rsp_inst,
  output logic [2:0]        rsp_class,
  output logic              rsp_err
);
  logic [NUM_SLOTS-1:0] hit;
  logic [NBANK-1:0]     l3_mask;
  logic [NMSLICE-1:0]   ms_mask;
  logic [BANK_IW-1:0]   l3_idx;
  logic [MS_IW-1:0]     ms_idx;
  logic                 l3_none, ms_none;
  logic [GRP_W-1:0]     ss_grp, nx_grp;
  logic [INST_W-1:0]    ss_inst, nx_inst;
  steer_cls_e           nx_cls;
  logic                 nx_err;

  steer_range_match #(.ADDR_W(ADDR_W)) u_match (
    .addr(req_addr), .slot_en(cls_en), .slot_hit(hit)
  );

  steer_presence #(.NBANK(NBANK), .NMSLICE(NMSLICE), .SS_PER_MS(SS_PER_MS)) u_pres (
    .l3_fuse(l3_fuse), .meml3_en(meml3_en), .ss_present(ss_present),
    .l3_mask(l3_mask), .ms_mask(ms_mask)
  );

  steer_pick #(.W(NBANK), .IW(BANK_IW)) u_pick_l3 (
    .mask(l3_mask), .idx(l3_idx), .none(l3_none)
  );

  steer_pick #(.W(NMSLICE), .IW(MS_IW)) u_pick_ms (
    .mask(ms_mask), .idx(ms_idx), .none(ms_none)
  );

  steer_ss_map #(.SSI_W(SSI_W), .SS_PER_SLICE(SS_PER_SLICE),
                 .GRP_W(GRP_W), .INST_W(INST_W)) u_ssmap (
    .ss_idx(req_addr[SSI_W-1:0]), .grp(ss_grp), .inst(ss_inst)
  );

  // priority select: first enabled class with a hit decides
  always_comb begin
    nx_grp  = dflt_group;
    nx_inst = dflt_inst;
    nx_cls  = CLS_DEFAULT;
    nx_err  = 1'b0;
    if (req_ss_mode) begin
      nx_grp  = ss_grp;
      nx_inst = ss_inst;
      nx_cls  = CLS_SSMAP;
    end else if (hit[SLOT_L3]) begin
      nx_cls  = CLS_L3BANK;
      nx_err  = l3_none;
      nx_grp  = '0;
      nx_inst = l3_none ? '0 : INST_W'(l3_idx);
    end else if (hit[SLOT_MS]) begin
      nx_cls  = CLS_MSLICE;
      nx_err  = ms_none;
      nx_grp  = ms_none ? '0 : GRP_W'(ms_idx);
      nx_inst = '0;
    end else if (hit[SLOT_LN]) begin
      nx_cls  = CLS_LNCF;
      nx_err  = ms_none;
      nx_grp  = ms_none ? '0 : GRP_W'({ms_idx, 1'b0});
      nx_inst = '0;
    end else if (hit[SLOT_I0]) begin
      nx_cls  = CLS_INST0;
      nx_grp  = '0;
      nx_inst = '0;
    end
  end

  // single output register stage
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_group <= '0;
      rsp_inst  <= '0;
      rsp_class <= 3'(CLS_DEFAULT);
      rsp_err   <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_group <= nx_grp;
        rsp_inst  <= nx_inst;
        rsp_class <= 3'(nx_cls);
        rsp_err   <= nx_err;
      end
    end
  end

  p_hold_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_group, rsp_inst, rsp_class, rsp_err}));

  p_accept_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_group == '0 && rsp_inst == '0);

  p_err_class_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_class inside {3'(CLS_L3BANK), 3'(CLS_MSLICE), 3'(CLS_LNCF)});

  p_l3_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_class == 3'(CLS_L3BANK) |-> rsp_group == '0);

  p_ms_inst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_class == 3'(CLS_MSLICE) |-> rsp_inst == '0);

  p_ln_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_class == 3'(CLS_LNCF) |-> rsp_group[0] == 1'b0 && rsp_inst == '0);

  p_inst0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_class == 3'(CLS_INST0) |-> rsp_group == '0 && rsp_inst == '0);

  p_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ss_mode && $onehot0(hit & cls_en) && hit == '0 && !req_ss_mode
      |-> nx_cls == CLS_DEFAULT);
endmodule

// File: tb/tb_steer_resolver.sv
module tb_steer_resolver;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 20 ns period, 50 MHz

  logic        rst_n;
  logic [3:0]  cls_en;
  logic [7:0]  l3_fuse;
  logic [3:0]  meml3_en;
  logic [15:0] ss_present;
  logic [3:0]  dflt_group, dflt_inst;
  logic        req_valid, req_ready, req_ss_mode;
  logic [23:0] req_addr;
  logic        rsp_valid, rsp_ready;
  logic [3:0]  rsp_group, rsp_inst;
  logic [2:0]  rsp_class;
  logic        rsp_err;

  steer_resolver dut (
    .clk(clk), .rst_n(rst_n), .cls_en(cls_en), .l3_fuse(l3_fuse),
    .meml3_en(meml3_en), .ss_present(ss_present), .dflt_group(dflt_group),
    .dflt_inst(dflt_inst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ss_mode(req_ss_mode), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_group(rsp_group), .rsp_inst(rsp_inst),
    .rsp_class(rsp_class), .rsp_err(rsp_err)
  );

  typedef struct packed {
    logic [3:0] g;
    logic [3:0] i;
    logic [2:0] c;
    logic       e;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit inr(input logic [23:0] a, input int lo, input int hi);
    return (int'(a) >= lo) && (int'(a) <= hi);
  endfunction

  // independent reference built from the requirements
  function automatic exp_t model(input logic [23:0] a, input logic ssm);
    exp_t r;
    bit h_l3, h_ms, h_ln, h_i0;
    int l3_low, ms_low;
    logic [7:0] l3m;
    logic [3:0] msm;
    r.e = 1'b0;
    if (ssm) begin
      r.g = 4'(a[3:0] / 4); r.i = 4'(a[3:0] % 4); r.c = 3'd5;
      return r;
    end
    l3m = ~l3_fuse;
    for (int m = 0; m < 4; m++) msm[m] = meml3_en[m] || (ss_present[m*4 +: 4] != 4'h0);
    l3_low = -1;
    for (int b = 7; b >= 0; b--) if (l3m[b]) l3_low = b;
    ms_low = -1;
    for (int b = 3; b >= 0; b--) if (msm[b]) ms_low = b;
    h_l3 = cls_en[0] && inr(a, 'hB100, 'hB3FF);
    h_ms = cls_en[1] && (inr(a, 'h4000, 'h4AFF) || inr(a, 'hC800, 'hCFFF) ||
                         inr(a, 'hDD00, 'hDDFF) || inr(a, 'hE900, 'hFFFF));
    h_ln = cls_en[2] && (inr(a, 'hB000, 'hB0FF) || inr(a, 'hD800, 'hD8FF));
    h_i0 = cls_en[3] && (inr(a, 'h8800, 'h887F) || inr(a, 'hB000, 'hB3FF));
    r.g = dflt_group; r.i = dflt_inst; r.c = 3'd0;
    if (h_l3) begin
      r.c = 3'd1; r.g = 4'd0;
      if (l3_low < 0) begin r.e = 1'b1; r.i = 4'd0; end else r.i = 4'(l3_low);
    end else if (h_ms) begin
      r.c = 3'd2; r.i = 4'd0;
      if (ms_low < 0) begin r.e = 1'b1; r.g = 4'd0; end else r.g = 4'(ms_low);
    end else if (h_ln) begin
      r.c = 3'd3; r.i = 4'd0;
      if (ms_low < 0) begin r.e = 1'b1; r.g = 4'd0; end else r.g = 4'(ms_low * 2);
    end else if (h_i0) begin
      r.c = 3'd4; r.g = 4'd0; r.i = 4'd0;
    end
    return r;
  endfunction

  // driver: push expectation, then hold the request until accepted
  task automatic send(input logic [23:0] a, input logic ssm, input string tag);
    bit rdy;
    eq.push_back(model(a, ssm));
    tq.push_back(tag);
    req_valid = 1'b1; req_addr = a; req_ss_mode = ssm;
    forever begin
      #1;
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (eq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: random back-pressure, stall hold check, scoreboard pop
  logic [7:0] lfsr = 8'hA5;
  bit         prev_stall = 1'b0;
  exp_t       held;
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = lfsr[0] | lfsr[2];
      #1;
      if (prev_stall)
        check(rsp_valid && {rsp_group, rsp_inst, rsp_class, rsp_err} == held, "R13",
              "stalled response changed", {rsp_valid, rsp_group, rsp_inst, rsp_class, rsp_err},
              {1'b1, held});
      prev_stall = rsp_valid && !rsp_ready;
      held = {rsp_group, rsp_inst, rsp_class, rsp_err};
      if (rsp_valid && rsp_ready) begin
        if (eq.size() == 0) begin
          check(1'b0, "R13", "unexpected response", 32'(held), 32'h0);
        end else begin
          exp_t e;
          string t;
          e = eq.pop_front();
          t = tq.pop_front();
          check(held == e, t, "group/inst/class/err", 32'(held), 32'(e));
        end
      end
    end
  end

  initial begin
    #150000000;
    check(1'b0, "R13", "watchdog expired", 32'(eq.size()), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rsp_ready = 1'b0; req_valid = 1'b0; req_ss_mode = 1'b0; req_addr = '0;
    cls_en = 4'hF; l3_fuse = 8'b0000_0111; meml3_en = 4'b0000; ss_present = 16'h0F00;
    dflt_group = 4'd5; dflt_inst = 4'd6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!rsp_valid && req_ready, "R13", "reset state", {rsp_valid, req_ready}, 2'b01);
    @(negedge clk);

    // R1 bounds, R3 L3 bank 3 present first, R9 inversion
    send(24'h00B100, 0, "R1"); send(24'h00B3FF, 0, "R1"); send(24'h00B180, 0, "R3");
    send(24'h00B400, 0, "R7"); send(24'h004000, 0, "R1"); send(24'h004AFF, 0, "R1");
    send(24'h004B00, 0, "R7"); send(24'h003FFF, 0, "R7"); send(24'h00E900, 0, "R4");
    send(24'h00FFFF, 0, "R4"); send(24'h00DD80, 0, "R4"); send(24'h00C800, 0, "R4");
    // R5 LN group = 2*slice 2 = 4; R2 LN beats I0 at 0xB0FF
    send(24'h00D800, 0, "R5"); send(24'h00D8FF, 0, "R5"); send(24'h00D900, 0, "R7");
    send(24'h00B0FF, 0, "R2");
    send(24'h008800, 0, "R6"); send(24'h00887F, 0, "R6"); send(24'h008880, 0, "R7");
    send(24'h000000, 0, "R7");
    // R12 subslice mapping
    send(24'h00000D, 1, "R12"); send(24'h000000, 1, "R12"); send(24'h00000F, 1, "R12");
    drain();

    // R10 / R2 fall-through with classes disabled
    cls_en = 4'b1110;
    send(24'h00B180, 0, "R10"); send(24'h00B050, 0, "R2");
    drain();
    cls_en = 4'b1010;
    send(24'h00B050, 0, "R10"); send(24'h00D800, 0, "R10");
    drain();
    cls_en = 4'b0000;
    send(24'h00B180, 0, "R10"); send(24'h004000, 0, "R10");
    drain();

    // R8 presence from memory enable alone, then from one subslice alone
    cls_en = 4'hF; meml3_en = 4'b0001; ss_present = 16'h0000; l3_fuse = 8'b1011_1111;
    send(24'h004000, 0, "R8"); send(24'h00B000, 0, "R8"); send(24'h00B100, 0, "R9");
    drain();
    meml3_en = 4'b0000; ss_present = 16'h8000;
    send(24'h004000, 0, "R8"); send(24'h00D800, 0, "R8");
    drain();

    // R11 empty presence masks
    l3_fuse = 8'hFF; ss_present = 16'h0000; meml3_en = 4'b0000;
    send(24'h00B100, 0, "R11"); send(24'h00CFFF, 0, "R11"); send(24'h00B000, 0, "R11");
    send(24'h008800, 0, "R11");
    drain();

    repeat (4) @(negedge clk);
    check(eq.size() == 0, "R13", "responses missing", 32'(eq.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule